// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits on the compute-unit side of a load/store port that serves one operation at a time. It takes a command (load or store, a 4-bit byte length, an address and store data) through a valid/ready handshake. It then runs the port handshake for that command: it raises a request with a held address, waits for the port to accept or reject the address, and then collects the load data or sends the store data. One result pulse reports completion, carrying load data or an exception flag.

The port raises busy for the whole of an operation. The requester never starts a new operation while busy is high. It holds its request, length and address steady until busy falls. It sends store data only after the address has been accepted, and it waits for no acknowledgement of that data. An abort input stops an operation in flight: it signals kill to the port for one cycle and returns the requester to idle without a result.

Top module: `ldstMaster`

## Requirements
- R1: After reset, cmdReady is high (with portBusy low) and portLd, portSt, portAddrValid, portStValid, portKill and resValid are all low.
- R2: cmdReady is high only while idle and portBusy is low. A command offered while portBusy is high is not taken, and no request follows.
- R3: In the cycle after a command is taken, exactly one request is high: portSt when cmdIsStore is 1, portLd when it is 0. portAddrValid is high with the command's address, and portLen equals cmdLen unchanged.
- R4: Request, address and length stay stable while busy is high. They drop in the same cycle in which busy falls after having been high.
- R5: portStValid is high for exactly one cycle, in the cycle after the portAddrAck pulse, and carries the command's store data. It is never high before the address is accepted.
- R6: For a load, data is taken in the cycle portLdValid is high. In the next cycle resValid is high with resExc 0 and resData equal to that data.
- R7: A portAddrExc pulse ends the operation with no data phase. In the next cycle resValid is high with resExc 1 and resData 0, and portStValid never rises.
- R8: For a store, resValid is high with resExc 0 in the cycle after the store data pulse, with no acknowledgement awaited. cmdReady returns once busy is low.
- R9: abortI during an operation drives portKill high in that same cycle. In the next cycle all requests are low and no result is given. abortI while idle leaves portKill low.
- R10: cmdReady stays low from the cycle after a command is taken until the requester is idle again with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| abortI | input | 1 | Abort the operation in flight |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be taken |
| cmdIsStore | input | 1 | 1 = store, 0 = load |
| cmdLen | input | 4 | Byte length of the access |
| cmdAddr | input | ADDR_W | Byte address |
| cmdData | input | DATA_W | Store data |
| resValid | output | 1 | One-cycle completion pulse |
| resExc | output | 1 | Completion was an address exception |
| resData | output | DATA_W | Load data (0 for store or exception) |
| portLd | output | 1 | Load request to the port |
| portSt | output | 1 | Store request to the port |
| portLen | output | 4 | Byte length to the port |
| portAddr | output | ADDR_W | Held address to the port |
| portAddrValid | output | 1 | Address valid |
| portStData | output | DATA_W | Store data to the port |
| portStValid | output | 1 | One-cycle store data pulse |
| portKill | output | 1 | Cancel the port operation |
| portBusy | input | 1 | Port has an operation in progress |
| portAddrAck | input | 1 | One-cycle address accepted pulse |
| portAddrExc | input | 1 | One-cycle address rejected pulse |
| portLdValid | input | 1 | One-cycle load data valid |
| portLdData | input | DATA_W | Load data |

## Verification
The request appears one clock after the command is taken. The store data pulse comes one clock after the accept pulse. resValid comes one clock after the load-data, exception or store-data pulse, and kill appears in the abort cycle itself. The bench drives the port inputs on falling edges and samples at the next falling edge, so each registered result is checked exactly one edge after its cause. Checks on combinational drops (requests falling with busy, kill) are made a moment after the inputs change, within the same half cycle.

// File: rtl/ldstPkg.sv
package ldstPkg;
  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_LDWAIT,
    S_STDATA,
    S_DRAIN
  } ctrlState_t;

  typedef struct packed {
    logic takeCmd;
    logic loadDone;
    logic storeDone;
    logic excDone;
  } dpStrobe_t;
endpackage

// File: rtl/ldstCtrl.sv
module ldstCtrl
  import ldstPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      abortI,
  input  logic      cmdValid,
  input  logic      opIsStore,
  input  logic      portBusy,
  input  logic      portAddrAck,
  input  logic      portAddrExc,
  input  logic      portLdValid,
  output logic      cmdReady,
  output logic      portLd,
  output logic      portSt,
  output logic      portAddrValid,
  output logic      portStValid,
  output logic      portKill,
  output dpStrobe_t strobe
);
  ctrlState_t state, stateNxt;
  logic busySeen;
  logic active, ending, reqOn;

  assign active   = (state != S_IDLE);
  assign ending   = busySeen && !portBusy;
  assign reqOn    = active && !ending;
  assign cmdReady = (state == S_IDLE) && !portBusy;

  assign portLd        = reqOn && !opIsStore;
  assign portSt        = reqOn && opIsStore;
  assign portAddrValid = reqOn;
  assign portStValid   = (state == S_STDATA);
  assign portKill      = abortI && active;

  always_comb begin
    strobe           = '0;
    strobe.takeCmd   = cmdValid && cmdReady;
    strobe.excDone   = (state == S_ADDR) && portAddrExc && !abortI;
    strobe.loadDone  = (state == S_LDWAIT) && portLdValid && !abortI;
    strobe.storeDone = (state == S_STDATA) && !abortI;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:   if (cmdValid && cmdReady) stateNxt = S_ADDR;
      S_ADDR: begin
        if (portAddrExc)      stateNxt = S_DRAIN;
        else if (portAddrAck) stateNxt = opIsStore ? S_STDATA : S_LDWAIT;
      end
      S_LDWAIT: if (portLdValid) stateNxt = S_DRAIN;
      S_STDATA: stateNxt = S_DRAIN;
      S_DRAIN:  if (!portBusy) stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
    if (abortI && active) stateNxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      busySeen <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE || stateNxt == S_IDLE) busySeen <= 1'b0;
      else                                       busySeen <= busySeen || portBusy;
    end
  end

  // R5
  st_pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    portStValid |=> !portStValid);

  // R5
  st_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    portStValid |-> $past(portAddrAck));

  // R9
  kill_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    portKill |=> (!portAddrValid && !portStValid));

  // R3
  take_then_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !abortI) |=> portAddrValid);
endmodule

// File: rtl/ldstDpath.sv
module ldstDpath
  import ldstPkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cmdIsStore,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] portLdData,
  output logic              opIsStore,
  output logic [LEN_W-1:0]  portLen,
  output logic [ADDR_W-1:0] portAddr,
  output logic [DATA_W-1:0] portStData,
  output logic              resValid,
  output logic              resExc,
  output logic [DATA_W-1:0] resData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opIsStore  <= 1'b0;
      portLen    <= '0;
      portAddr   <= '0;
      portStData <= '0;
    end else if (strobe.takeCmd) begin
      opIsStore  <= cmdIsStore;
      portLen    <= cmdLen;
      portAddr   <= cmdAddr;
      portStData <= cmdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resExc   <= 1'b0;
      resData  <= '0;
    end else begin
      resValid <= strobe.loadDone || strobe.storeDone || strobe.excDone;
      resExc   <= strobe.excDone;
      if (strobe.loadDone)                        resData <= portLdData;
      else if (strobe.storeDone || strobe.excDone) resData <= '0;
    end
  end

  // R7
  exc_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resExc) |-> (resData == '0));
endmodule

// File: rtl/ldstMaster.sv
module ldstMaster
  import ldstPkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abortI,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdIsStore,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              resValid,
  output logic              resExc,
  output logic [DATA_W-1:0] resData,
  output logic              portLd,
  output logic              portSt,
  output logic [LEN_W-1:0]  portLen,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portAddrValid,
  output logic [DATA_W-1:0] portStData,
  output logic              portStValid,
  output logic              portKill,
  input  logic              portBusy,
  input  logic              portAddrAck,
  input  logic              portAddrExc,
  input  logic              portLdValid,
  input  logic [DATA_W-1:0] portLdData
);
  dpStrobe_t strobe;
  logic opIsStore;

  ldstCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .abortI(abortI), .cmdValid(cmdValid),
    .opIsStore(opIsStore), .portBusy(portBusy), .portAddrAck(portAddrAck),
    .portAddrExc(portAddrExc), .portLdValid(portLdValid),
    .cmdReady(cmdReady), .portLd(portLd), .portSt(portSt),
    .portAddrValid(portAddrValid), .portStValid(portStValid),
    .portKill(portKill), .strobe(strobe)
  );

  ldstDpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdIsStore(cmdIsStore),
    .cmdLen(cmdLen), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .portLdData(portLdData), .opIsStore(opIsStore), .portLen(portLen),
    .portAddr(portAddr), .portStData(portStData), .resValid(resValid),
    .resExc(resExc), .resData(resData)
  );

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portAddrValid && $past(portAddrValid)) |-> ($stable(portAddr) && $stable(portLen)));

  // R6
  res_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(portLdValid || portAddrExc || portStValid));
endmodule

// File: tb/ldstMaster_bench.sv
module ldstMaster_bench;
  localparam int AW = 48;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abortI = 0, cmdValid = 0, cmdIsStore = 0;
  logic [3:0] cmdLen = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic portBusy = 0, portAddrAck = 0, portAddrExc = 0, portLdValid = 0;
  logic [DW-1:0] portLdData = '0;
  logic cmdReady, resValid, resExc, portLd, portSt, portAddrValid, portStValid, portKill;
  logic [DW-1:0] resData, portStData;
  logic [3:0] portLen;
  logic [AW-1:0] portAddr;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  ldstMaster #(.ADDR_W(AW), .DATA_W(DW)) u_ldstMaster (
    .clk(clk), .rstN(rstN), .abortI(abortI), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdIsStore(cmdIsStore), .cmdLen(cmdLen),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .resValid(resValid),
    .resExc(resExc), .resData(resData), .portLd(portLd), .portSt(portSt),
    .portLen(portLen), .portAddr(portAddr), .portAddrValid(portAddrValid),
    .portStData(portStData), .portStValid(portStValid), .portKill(portKill),
    .portBusy(portBusy), .portAddrAck(portAddrAck), .portAddrExc(portAddrExc),
    .portLdValid(portLdValid), .portLdData(portLdData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  task automatic issue(input bit st, input logic [3:0] len, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    @(negedge clk);
    cmdValid = 1; cmdIsStore = st; cmdLen = len; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic tReset();
    check(cmdReady == 1, "R1 ready", 64'(cmdReady), 1);
    check({portLd, portSt, portAddrValid, portStValid, portKill, resValid} == 0,
          "R1 outputs", 64'({portLd, portSt, portAddrValid, portStValid, portKill, resValid}), 0);
  endtask

  task automatic tLoad(input logic [3:0] len, input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(0, len, a, '0);
    check(portLd && !portSt && portAddrValid, "R3 load request",
          64'({portLd, portSt, portAddrValid}), 64'b101);
    check(portAddr == a, "R3 addr", 64'(portAddr), 64'(a));
    check(portLen == len, "R3 len", 64'(portLen), 64'(len));
    check(cmdReady == 0, "R10 ready low", 64'(cmdReady), 0);
    portBusy = 1;
    @(negedge clk);
    check(portAddr == a && portLd, "R4 held", 64'(portAddr), 64'(a));
    portAddrAck = 1;
    @(negedge clk);
    portAddrAck = 0;
    check(portAddrValid == 1, "R4 held after ack", 64'(portAddrValid), 1);
    portLdValid = 1; portLdData = d; portBusy = 0;
    #1;
    check(portLd == 0 && portAddrValid == 0, "R4 drop with busy",
          64'({portLd, portAddrValid}), 0);
    @(negedge clk);
    portLdValid = 0; portLdData = '0;
    check(resValid && !resExc, "R6 result valid", 64'({resValid, resExc}), 64'b10);
    check(resData == d, "R6 data", resData, d);
    @(negedge clk);
    check(resValid == 0, "R6 pulse", 64'(resValid), 0);
    check(cmdReady == 1, "R10 ready back", 64'(cmdReady), 1);
  endtask

  task automatic tStore(input logic [3:0] len, input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1, len, a, d);
    check(portSt && !portLd && portAddrValid, "R3 store request",
          64'({portLd, portSt, portAddrValid}), 64'b011);
    portBusy = 1;
    @(negedge clk);
    check(portStValid == 0, "R5 no data before ack", 64'(portStValid), 0);
    portAddrAck = 1;
    @(negedge clk);
    portAddrAck = 0;
    check(portStValid == 1, "R5 data pulse", 64'(portStValid), 1);
    check(portStData == d, "R5 data value", portStData, d);
    check(resValid == 0, "R8 no early result", 64'(resValid), 0);
    @(negedge clk);
    portBusy = 0;
    check(portStValid == 0, "R5 one cycle", 64'(portStValid), 0);
    check(resValid && !resExc, "R8 store result", 64'({resValid, resExc}), 64'b10);
    @(negedge clk);
    check(cmdReady == 1, "R8 ready after store", 64'(cmdReady), 1);
  endtask

  task automatic tExc();
    issue(1, 4'h4, 48'h1000, 64'h55);
    portBusy = 1;
    @(negedge clk);
    portAddrExc = 1; portBusy = 0;
    @(negedge clk);
    portAddrExc = 0;
    check(resValid && resExc, "R7 exc result", 64'({resValid, resExc}), 64'b11);
    check(resData == 0, "R7 data zero", resData, 0);
    check(portStValid == 0, "R7 no data phase", 64'(portStValid), 0);
    @(negedge clk);
    check(portStValid == 0 && cmdReady == 1, "R7 idle", 64'({portStValid, cmdReady}), 64'b01);
  endtask

  task automatic tAbort();
    issue(0, 4'h2, 48'h2222, '0);
    portBusy = 1;
    @(negedge clk);
    portAddrAck = 1;
    @(negedge clk);
    portAddrAck = 0; abortI = 1;
    #1;
    check(portKill == 1, "R9 kill", 64'(portKill), 1);
    @(negedge clk);
    abortI = 0; portBusy = 0;
    #1;
    check({portLd, portAddrValid, portKill, resValid} == 0, "R9 back to idle",
          64'({portLd, portAddrValid, portKill, resValid}), 0);
    @(negedge clk);
    abortI = 1;
    #1;
    check(portKill == 0, "R9 idle abort ignored", 64'(portKill), 0);
    @(negedge clk);
    abortI = 0;
    check(cmdReady == 1 && portAddrValid == 0, "R9 still idle",
          64'({cmdReady, portAddrValid}), 64'b10);
  endtask

  task automatic tBlocked();
    @(negedge clk);
    portBusy = 1; cmdValid = 1; cmdIsStore = 0;
    #1;
    check(cmdReady == 0, "R2 ready low while busy", 64'(cmdReady), 0);
    @(negedge clk);
    check(portLd == 0 && portAddrValid == 0, "R2 not taken",
          64'({portLd, portAddrValid}), 0);
    cmdValid = 0; portBusy = 0;
    @(negedge clk);
    check(portAddrValid == 0 && cmdReady == 1, "R2 still idle",
          64'({portAddrValid, cmdReady}), 64'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tLoad(4'h8, 48'h0000_1234_5678, 64'hDEAD_BEEF_0123_4567);
    tLoad(4'h1, 48'hFFFF_FFFF_FFF8, 64'h0000_0000_0000_00A5);
    tStore(4'h4, 48'h0000_0000_0040, 64'hCAFE_F00D_1111_2222);
    tExc();
    tAbort();
    tBlocked();
    tStore(4'hF, 48'hABCD_0000_0010, 64'h8000_0000_0000_0001);
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
    summary();
  end
endmodule